// File: doc/BRIEF.md
# Byte-Wide Memory with Clock Register Window

This block is an 8192 x 8 static memory reached over a parallel bus: a 13-bit address, separate data-in and data-out buses, two chip enables of opposite sense, a write enable, an output enable and a power-fail inhibit. Every address except the top eight behaves as plain storage. The top eight addresses form a clock register window. Software reads and writes them like RAM, but behind them sits a chain of BCD time-of-day counters. The counters are driven by a one-second tick, which is derived from a 1024 Hz strobe input.

The window bytes are holding registers, not the counters. On each second the counter values are copied into the window unless the control byte asks for a stable snapshot (read hold) or is being used to set the time (write hold). When the write hold is released, the window contents are loaded into the counters in a single clock. A stop flag halts the count. A frequency-test flag routes a 512 Hz square wave to a dedicated output. A signed calibration field is stored and read back. Oscillator trimming is not part of this block.

The bus is a plain synchronous strobe interface, not a stream. Writes land on the rising clock edge. Read data follows the address and the state combinationally. There is no back-pressure: every access completes in the cycle in which it is presented.

Top module: `clock_window_ram`

## Requirements
- R1: An address below 1FF8h stores the byte written to it and returns that byte when read. The address is 13 bits wide and the data is 8 bits wide.
- R2: `dq_oe` is 1 exactly when `ce1_n`=0, `ce2`=1, `oe_n`=0 and `we_n`=1. Holding `we_n` low releases the bus.
- R3: Addresses 1FF8h to 1FFFh map, in that order, to control, seconds, minutes, hours, day-of-week, date, month and year. After reset these bytes read 00h, 00h, 00h, 00h, 01h, 01h, 01h, 00h.
- R4: A write is stored at the rising edge only when `ce1_n`=0, `ce2`=1 and `we_n`=0. With any chip enable inactive, nothing is stored.
- R5: While `pwr_fail`=1, no write changes RAM or any window byte.
- R6: Every 1024 strobes the counters advance one second in BCD, and the window's counter bits follow on the next edge. Rollover covers 59 s, 59 min and 23 h. Day-of-week wraps from 7 to 1. Months have 28, 29, 30 or 31 days, and February has 29 when the year (00 to 99) is divisible by 4. The year wraps from 99 to 00.
- R7: While control bit 6 (read hold) is 1, the window is not refreshed, but the counters keep running.
- R8: While control bit 7 (write hold) is 1, the window is not refreshed. On the clock after bit 7 is written from 1 to 0, the counters load the window's time fields.
- R9: While seconds bit 7 (stop) is 1, the counters do not advance.
- R10: When day-of-week bit 6 (frequency test) is 1, `freq_out` toggles on every strobe, which gives 512 Hz. Otherwise `freq_out` is 0.
- R11: Bits with no counter behind them read back as last written. These are control bits 5:0 (bit 5 is the sign, bits 4:0 the calibration), seconds bit 7, minutes bit 7, hours bits 7:6, day bits 7:3, date bits 7:6 and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| dq_out | output | 8 | Read data, valid while dq_oe is 1 |
| dq_oe | output | 1 | Bus drive enable |
| pwr_fail | input | 1 | Supply out of tolerance: blocks all writes |
| tick_strobe | input | 1 | 1024 Hz time-base strobe, one clock wide |
| freq_out | output | 1 | 512 Hz test wave when enabled |

## Verification
On every cycle, the assertions check several properties. The window stays frozen under power fail, apart from a scheduled refresh. Read hold keeps the time bytes still. The counters hold whenever they are neither ticked nor loaded. A load copies the window exactly. The prescaler restarts after each second. Calendar rollovers, the BCD carry chain across month and year ends, and the order of hold, load and refresh can be seen only through the bench's scenarios, which set particular dates and compare a behavioural model on every clock.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int unsigned SLOT_CTRL = 0;
  localparam int unsigned SLOT_SEC  = 1;
  localparam int unsigned SLOT_DOW  = 4;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } tod_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    if (y[4] == 1'b0) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                     return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

  // bits of each window slot that are refreshed from the counters
  function automatic logic [7:0] field_mask(input int unsigned s);
    case (s)
      1, 2:    return 8'h7F;
      3, 5:    return 8'h3F;
      4:       return 8'h07;
      6:       return 8'h1F;
      7:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] slot_reset(input int unsigned s);
    return (s >= 4 && s <= 6) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/cw_ram_array.sv
module cw_ram_array #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cw_prescaler.sv
module cw_prescaler #(
  parameter int unsigned PRESCALE = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic sec_pulse,
  output logic half_wave
);
  localparam int unsigned CW = $clog2(PRESCALE);
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  assign sec_pulse = strobe && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      half_wave <= 1'b0;
    end else if (strobe) begin
      cnt_q     <= sec_pulse ? '0 : cnt_q + 1'b1;
      half_wave <= ~half_wave;
    end
  end

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> (cnt_q == '0));
endmodule

// File: rtl/cw_time_count.sv
module cw_time_count
  import cw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic load,
  input  tod_t load_val,
  output tod_t tod
);
  tod_t nxt;

  always_comb begin
    nxt     = tod;
    nxt.sec = bcd_inc(tod.sec);
    if (tod.sec == 8'h59) begin
      nxt.sec = 8'h00;
      nxt.min = bcd_inc(tod.min);
      if (tod.min == 8'h59) begin
        nxt.min = 8'h00;
        nxt.hr  = bcd_inc(tod.hr);
        if (tod.hr == 8'h23) begin
          nxt.hr   = 8'h00;
          nxt.dow  = (tod.dow == 8'h07) ? 8'h01 : bcd_inc(tod.dow);
          nxt.date = bcd_inc(tod.date);
          if (tod.date == last_date(tod.mon, tod.yr)) begin
            nxt.date = 8'h01;
            nxt.mon  = bcd_inc(tod.mon);
            if (tod.mon == 8'h12) begin
              nxt.mon = 8'h01;
              nxt.yr  = (tod.yr == 8'h99) ? 8'h00 : bcd_inc(tod.yr);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod <= '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
               hr: 8'h00, min: 8'h00, sec: 8'h00};
    end else if (load) begin
      tod <= load_val;
    end else if (adv) begin
      tod <= nxt;
    end
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(tod));
endmodule

// File: rtl/clock_window_ram.sv
module clock_window_ram
  import cw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PRESCALE = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic              pwr_fail,
  input  logic              tick_strobe,
  output logic              freq_out
);
  localparam int unsigned SLOTS  = 8;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic                  sel, bus_wr, win_hit, win_wr;
  logic [SLOT_W-1:0]     slot;
  logic [DATA_W-1:0]     ram_rd;
  logic [SLOTS-1:0][7:0] win_q;
  logic [SLOTS-1:1][7:0] tod_slots;
  logic                  refresh_q, wflag_q, refresh_go, load_go;
  logic                  sec_pulse, half_wave, stop, adv;
  tod_t                  tod, load_val;

  assign sel     = !ce1_n && ce2;
  assign bus_wr  = sel && !we_n && !pwr_fail;
  assign win_hit = &addr[ADDR_W-1:SLOT_W];
  assign slot    = addr[SLOT_W-1:0];
  assign win_wr  = bus_wr && win_hit;

  cw_ram_array #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (bus_wr && !win_hit),
    .addr  (addr),
    .wdata (wdata),
    .rdata (ram_rd)
  );

  cw_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (tick_strobe),
    .sec_pulse (sec_pulse),
    .half_wave (half_wave)
  );

  assign stop = win_q[SLOT_SEC][7];
  assign adv  = sec_pulse && !stop;

  // hold bits: [7] write hold, [6] read hold
  assign refresh_go = refresh_q && !win_q[SLOT_CTRL][7] && !win_q[SLOT_CTRL][6];
  assign load_go    = wflag_q && !win_q[SLOT_CTRL][7];

  assign load_val = '{
    yr:   win_q[7] & field_mask(7), mon: win_q[6] & field_mask(6),
    date: win_q[5] & field_mask(5), dow: win_q[4] & field_mask(4),
    hr:   win_q[3] & field_mask(3), min: win_q[2] & field_mask(2),
    sec:  win_q[1] & field_mask(1)};

  cw_time_count u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load     (load_go),
    .load_val (load_val),
    .tod      (tod)
  );

  assign tod_slots = {tod.yr, tod.mon, tod.date, tod.dow, tod.hr, tod.min, tod.sec};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) win_q[i] <= slot_reset(i);
      refresh_q <= 1'b0;
      wflag_q   <= 1'b0;
    end else begin
      refresh_q <= sec_pulse;
      wflag_q   <= win_q[SLOT_CTRL][7];
      if (win_wr && slot == SLOT_W'(SLOT_CTRL)) win_q[SLOT_CTRL] <= wdata;
      for (int i = 1; i < SLOTS; i++) begin
        if (win_wr && slot == SLOT_W'(i))
          win_q[i] <= wdata;
        else if (refresh_go)
          win_q[i] <= (win_q[i] & ~field_mask(i)) | (tod_slots[i] & field_mask(i));
      end
    end
  end

  assign dq_oe    = sel && !oe_n && we_n;
  assign dq_out   = win_hit ? win_q[slot] : ram_rd;
  assign freq_out = win_q[SLOT_DOW][6] && half_wave;

  assert_pf_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail && !refresh_go) |=> $stable(win_q));

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q[SLOT_CTRL][6] && !win_wr) |=> $stable(win_q[SLOTS-1:1]));

  assert_load_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (tod == $past(load_val)));
endmodule

// File: tb/tb_clock_window_ram.sv
module tb_clock_window_ram;
  localparam int CLK_P = 10;
  localparam int PS    = 1024;
  localparam int BASE  = 'h1FF8;

  logic clk = 0, rst_n = 0;
  logic ce1_n = 1, ce2 = 0, we_n = 1, oe_n = 1, pwr_fail = 0, tick_strobe = 0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  dq_out;
  logic        dq_oe, freq_out;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  clock_window_ram dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .dq_out(dq_out), .dq_oe(dq_oe),
    .pwr_fail(pwr_fail), .tick_strobe(tick_strobe), .freq_out(freq_out));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ram [int];
  int m_win [8];
  int m_cnt [8];           // binary values, index = window slot
  int m_pre, m_tog, m_wrq, m_refq;
  int mk [8] = '{'h00, 'h7F, 'h7F, 'h3F, 'h07, 'h3F, 'h1F, 'hFF};

  function automatic int bcd(input int v); return (v / 10) * 16 + v % 10; endfunction
  function automatic int bin(input int v); return (v / 16) * 10 + v % 16; endfunction
  function automatic int days_in(input int mo, input int yr);
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    return 31;
  endfunction

  always @(posedge clk) begin : model
    int o [8];
    int oc [8];
    int nc [8];
    bit wr, pulse, load;
    if (!rst_n) begin
      m_win = '{0, 0, 0, 0, 1, 1, 1, 0};
      m_cnt = '{0, 0, 0, 0, 1, 1, 1, 0};
      m_pre = 0; m_tog = 0; m_wrq = 0; m_refq = 0;
    end else begin
      o = m_win; oc = m_cnt; nc = m_cnt;
      wr    = !ce1_n && ce2 && !we_n && !pwr_fail;
      pulse = tick_strobe && (m_pre == PS - 1);
      load  = m_wrq && ((o[0] & 'h80) == 0);
      if (load) begin
        for (int k = 1; k < 8; k++) nc[k] = bin(o[k] & mk[k]);
      end else if (pulse && ((o[1] & 'h80) == 0)) begin
        nc[1]++;
        if (nc[1] == 60) begin
          nc[1] = 0; nc[2]++;
          if (nc[2] == 60) begin
            nc[2] = 0; nc[3]++;
            if (nc[3] == 24) begin
              nc[3] = 0;
              nc[4] = (nc[4] == 7) ? 1 : nc[4] + 1;
              nc[5]++;
              if (nc[5] > days_in(oc[6], oc[7])) begin
                nc[5] = 1; nc[6]++;
                if (nc[6] == 13) begin nc[6] = 1; nc[7] = (nc[7] + 1) % 100; end
              end
            end
          end
        end
      end
      if (m_refq && ((o[0] & 'hC0) == 0))
        for (int k = 1; k < 8; k++) m_win[k] = (o[k] & ~mk[k] & 'hFF) | (bcd(oc[k]) & mk[k]);
      if (wr) begin
        if (addr >= BASE) m_win[addr - BASE] = wdata;
        else m_ram[int'(addr)] = wdata;
      end
      m_cnt  = nc;
      m_refq = pulse;
      m_wrq  = ((o[0] & 'h80) != 0);
      if (tick_strobe) begin
        m_pre = pulse ? 0 : m_pre + 1;
        m_tog ^= 1;
      end
    end
  end

  // every-clock comparison, a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      chk("R2 bus drive vs model", dq_oe, (!ce1_n && ce2 && !oe_n && we_n));
      chk("R10 freq_out vs model", freq_out, ((m_win[4] & 'h40) != 0) && m_tog);
      if (dq_oe) begin
        if (addr >= BASE) chk("R3 window byte vs model", dq_out, m_win[addr - BASE]);
        else if (m_ram.exists(int'(addr))) chk("R1 ram byte vs model", dq_out, m_ram[int'(addr)]);
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 13'(a); wdata = 8'(d); ce1_n = 0; ce2 = 1; we_n = 0; oe_n = 1;
    @(negedge clk);
    we_n = 1; ce1_n = 1; ce2 = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 13'(a); ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 0;
    #1 d = dq_out;
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    int d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int dw,
                          input int dt, input int mo, input int y);
    wr(BASE, 'hA5);            // write hold on, sign/cal 25h
    wr(BASE + 1, s);  wr(BASE + 2, mi); wr(BASE + 3, h);
    wr(BASE + 4, dw); wr(BASE + 5, dt); wr(BASE + 6, mo); wr(BASE + 7, y);
    wr(BASE, 'h25);            // release: counters load
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int d, s0, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R3 reset values
    rd_chk("R3 ctrl reset", BASE, 'h00);
    rd_chk("R3 sec reset", BASE + 1, 'h00);
    rd_chk("R3 dow reset", BASE + 4, 'h01);
    rd_chk("R3 date reset", BASE + 5, 'h01);
    rd_chk("R3 month reset", BASE + 6, 'h01);
    rd_chk("R3 year reset", BASE + 7, 'h00);
    chk("R10 freq_out idle", freq_out, 0);

    // R1 plain storage
    wr('h0000, 'hA5); wr('h1FF7, 'h3C); wr('h0ABC, 'h5A);
    rd_chk("R1 ram 0000", 'h0000, 'hA5);
    rd_chk("R1 ram 1FF7", 'h1FF7, 'h3C);
    rd_chk("R1 ram 0ABC", 'h0ABC, 'h5A);

    // R2 bus release cases
    @(negedge clk); addr = 0; ce1_n = 0; ce2 = 0; we_n = 1; oe_n = 0;
    #1 chk("R2 ce2 low releases", dq_oe, 0);
    @(negedge clk); ce2 = 1; oe_n = 1;
    #1 chk("R2 oe_n high releases", dq_oe, 0);
    @(negedge clk); oe_n = 0; we_n = 0; wdata = 'hA5;
    #1 chk("R2 we_n low releases", dq_oe, 0);
    @(negedge clk); we_n = 1; ce1_n = 1;

    // R4 no store with chip deselected
    @(negedge clk); addr = 0; wdata = 'hFF; ce1_n = 1; ce2 = 1; we_n = 0;
    @(negedge clk); ce1_n = 0; ce2 = 0;
    @(negedge clk); we_n = 1;
    rd_chk("R4 deselected write ignored", 'h0000, 'hA5);

    // R5 power fail blocks writes
    @(negedge clk); pwr_fail = 1;
    wr('h0000, 'h11); wr(BASE + 2, 'h33); wr(BASE, 'h40);
    @(negedge clk); pwr_fail = 0;
    rd_chk("R5 ram unchanged", 'h0000, 'hA5);
    rd_chk("R5 minutes unchanged", BASE + 2, 'h00);
    rd_chk("R5 ctrl unchanged", BASE, 'h00);

    // R11 calibration field readback
    wr(BASE, 'h25);
    rd_chk("R11 ctrl sign/cal readback", BASE, 'h25);

    // R6 first second with continuous strobe
    @(negedge clk); tick_strobe = 1;
    repeat (PS + 8) @(negedge clk);
    rd_chk("R6 one second elapsed", BASE + 1, 'h01);

    // R8/R6 leap day: 24-02-28 23:59:58, dow 7
    set_time('h58, 'h59, 'h23, 'h07, 'h28, 'h02, 'h24);
    rd_chk("R8 window holds set value", BASE + 1, 'h58);
    repeat (3 * PS) @(negedge clk);
    rd_chk("R6 leap date 29", BASE + 5, 'h29);
    rd_chk("R6 leap month stays 02", BASE + 6, 'h02);
    rd_chk("R6 hour wraps 00", BASE + 3, 'h00);
    rd_chk("R6 dow 7 to 1", BASE + 4, 'h01);

    // R6 non-leap February
    set_time('h58, 'h59, 'h23, 'h03, 'h28, 'h02, 'h23);
    repeat (3 * PS) @(negedge clk);
    rd_chk("R6 non-leap date 01", BASE + 5, 'h01);
    rd_chk("R6 non-leap month 03", BASE + 6, 'h03);

    // R6 end of century-year
    set_time('h58, 'h59, 'h23, 'h05, 'h31, 'h12, 'h99);
    repeat (3 * PS) @(negedge clk);
    rd_chk("R6 year 99 to 00", BASE + 7, 'h00);
    rd_chk("R6 month 12 to 01", BASE + 6, 'h01);
    rd_chk("R6 date 31 to 01", BASE + 5, 'h01);

    // R7 read hold
    wr(BASE, 'h65);
    rd(BASE + 1, s0);
    repeat (2 * PS + 50) @(negedge clk);
    rd_chk("R7 snapshot frozen", BASE + 1, s0);
    wr(BASE, 'h25);
    repeat (PS + 20) @(negedge clk);
    rd(BASE + 1, d);
    chk("R7 counters kept running", (d != s0) && (d > s0 + 1), 1);

    // R9 stop bit: load sec 00 with stop set
    wr(BASE, 'hA5); wr(BASE + 1, 'h80); wr(BASE, 'h25);
    repeat (2 * PS + 50) @(negedge clk);
    rd_chk("R9 stopped seconds", BASE + 1, 'h80);
    wr(BASE + 1, 'h00);

    // R10 frequency test
    rd(BASE + 4, d);
    wr(BASE + 4, d | 'h40);
    cnt = 0; s0 = freq_out;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (freq_out != s0) cnt++;
      s0 = freq_out;
    end
    chk("R10 toggles each strobe", cnt, 10);
    rd(BASE + 4, d);
    wr(BASE + 4, d & 'hBF);
    @(negedge clk); @(negedge clk);
    chk("R10 disabled output low", freq_out, 0);

    // R11 minutes bit 7 survives refresh
    rd(BASE + 2, d);
    wr(BASE + 2, d | 'h80);
    repeat (PS + 20) @(negedge clk);
    rd(BASE + 2, d);
    chk("R11 minutes flag kept", (d >> 7) & 1, 1);

    @(negedge clk); tick_strobe = 0; ce1_n = 1; ce2 = 0; oe_n = 1;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule